// File: doc/BRIEF.md
# One-Shot Edge-Aligned PWM Timer

This block is a PWM time base that, in its one-shot mode, produces a single edge-aligned pulse train per arming. Software selects the mode through a 2-bit field and pulses an arm input. When it arms in one-shot mode, every channel with a non-zero compare value drives its output high, and a 15-bit timer starts counting up from zero, one step per clock.

Each channel compares the timer against its own compare value and drops its output when the timer reaches it. When the timer reaches the period value, the run ends: the timer returns to zero, every output drops, the running status clears itself and a one-cycle interrupt pulse is raised. A new pulse needs a new arm request.

Top module: `oneshot_pwm`

## Requirements
- R1: While reset is asserted, and after it is released with no arm request, `run_o`, `irq_o` and every bit of `pwm_o` are low.
- R2: An arm request (`arm_i` high at a clock edge while idle) starts a run only when `mode_i` equals 2'b10. In modes 2'b00, 2'b01 and 2'b11 it has no effect: `run_o` and `pwm_o` stay low.
- R3: In the cycle after an accepted arm request, `run_o` is high and every channel whose compare value is non-zero has its `pwm_o` bit high.
- R4: A channel with compare value D, where 1 <= D <= period, keeps its output high for exactly D clock cycles, counted from the first cycle in which `run_o` is high.
- R5: A channel with compare value 0 never goes high during a run.
- R6: A channel whose compare value is greater than the period keeps its output high for the whole run, period+1 cycles. No output is ever high while `run_o` is low.
- R7: `run_o` stays high for exactly period+1 cycles, then clears itself. A period of 0 gives a one-cycle run.
- R8: `irq_o` goes high for exactly one cycle, the first cycle in which `run_o` is low after a run, and at no other time.
- R9: An arm request while a run is in progress is ignored. The run length is unchanged.
- R10: After a run ends, the block stays idle, with the timer held at zero and all outputs low, until a new arm request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 2 | Time-base mode; 2'b10 selects one-shot |
| arm_i | input | 1 | Arm request, sampled at each clock edge |
| period_i | input | 15 | Period compare value |
| duty_i | input | 45 | Per-channel compare values; channel k in bits [15k+14:15k] |
| pwm_o | output | 3 | Channel outputs, active high |
| run_o | output | 1 | Running status; clears itself at period match |
| irq_o | output | 1 | One-cycle interrupt pulse at the end of a run |

## Verification
On every cycle, the bound assertions check these properties:
- the interrupt is a single cycle that coincides with the fall of the running status;
- running ends only through that interrupt;
- outputs and the timer stay at rest while idle;
- an arm request in a mode other than 2'b10 never starts a run;
- the channels come up according to their compare values.

The exact number of cycles each channel stays high and the length of a run depend on the compare values. Only the bench's scenarios show these counts. The bench runs ordinary compare values, zero values, values above the period and a zero period. It also shows that an arm request during a run leaves the run length unchanged.

// File: rtl/oneshot_pwm_pkg.sv
package oneshot_pwm_pkg;
  localparam logic [1:0] MODE_ONESHOT = 2'b10;
endpackage

// File: rtl/oneshot_pwm_rst_sync.sv
module oneshot_pwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/oneshot_pwm_timebase.sv
module oneshot_pwm_timebase
  import oneshot_pwm_pkg::*;
#(
  parameter int TW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic          arm_i,
  input  logic [TW-1:0] period_i,
  output logic          run_o,
  output logic          start_o,
  output logic          pmatch_o,
  output logic [TW-1:0] tmr_o,
  output logic [TW-1:0] tmr_nxt_o,
  output logic          irq_o
);
  logic          run_q, run_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          irq_q, irq_d;
  logic          start, pmatch, tmr_en;

  // next-state logic
  always_comb begin
    start  = arm_i & ~run_q & (mode_i == MODE_ONESHOT);
    pmatch = run_q & (tmr_q == period_i);
    tmr_en = run_q;
    if (start)       run_d = 1'b1;
    else if (pmatch) run_d = 1'b0;
    else             run_d = run_q;
    if (pmatch) tmr_d = '0;
    else        tmr_d = tmr_q + 1'b1;
    irq_d = pmatch;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      tmr_q <= '0;
      irq_q <= 1'b0;
    end else begin
      run_q <= run_d;
      irq_q <= irq_d;
      if (tmr_en) tmr_q <= tmr_d;
    end
  end

  assign run_o     = run_q;
  assign start_o   = start;
  assign pmatch_o  = pmatch;
  assign tmr_o     = tmr_q;
  assign tmr_nxt_o = tmr_d;
  assign irq_o     = irq_q;
endmodule

// File: rtl/oneshot_pwm_chan.sv
module oneshot_pwm_chan #(
  parameter int TW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          run_i,
  input  logic          pmatch_i,
  input  logic [TW-1:0] tmr_nxt_i,
  input  logic [TW-1:0] duty_i,
  output logic          pwm_o
);
  logic pwm_q, pwm_d, ch_en;

  always_comb begin
    ch_en = start_i | run_i;
    if (start_i)                    pwm_d = (duty_i != '0);
    else if (pmatch_i)              pwm_d = 1'b0;
    else if (tmr_nxt_i == duty_i)   pwm_d = 1'b0;
    else                            pwm_d = pwm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pwm_q <= 1'b0;
    else if (ch_en) pwm_q <= pwm_d;
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/oneshot_pwm.sv
module oneshot_pwm #(
  parameter int NCH = 3,
  parameter int TW  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              arm_i,
  input  logic [TW-1:0]     period_i,
  input  logic [NCH*TW-1:0] duty_i,
  output logic [NCH-1:0]    pwm_o,
  output logic              run_o,
  output logic              irq_o
);
  logic          rst_n_s;
  logic          start_w, pmatch_w;
  logic [TW-1:0] tmr_w, tmr_nxt_w;

  oneshot_pwm_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  oneshot_pwm_timebase #(.TW(TW)) u_tb (
    .clk(clk), .rst_n(rst_n_s), .mode_i(mode_i), .arm_i(arm_i),
    .period_i(period_i), .run_o(run_o), .start_o(start_w),
    .pmatch_o(pmatch_w), .tmr_o(tmr_w), .tmr_nxt_o(tmr_nxt_w),
    .irq_o(irq_o)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    oneshot_pwm_chan #(.TW(TW)) u_ch (
      .clk(clk), .rst_n(rst_n_s), .start_i(start_w), .run_i(run_o),
      .pmatch_i(pmatch_w), .tmr_nxt_i(tmr_nxt_w),
      .duty_i(duty_i[k*TW +: TW]), .pwm_o(pwm_o[k])
    );
  end
endmodule

// File: rtl/oneshot_pwm_checker.sv
module oneshot_pwm_checker #(
  parameter int NCH = 3,
  parameter int TW  = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_i,
  input logic              arm_i,
  input logic [NCH*TW-1:0] duty_i,
  input logic [NCH-1:0]    pwm_o,
  input logic              run_o,
  input logic              irq_o,
  input logic [TW-1:0]     tmr_w
);
  logic [NCH-1:0] nz;
  always_comb
    for (int k = 0; k < NCH; k++) nz[k] = (duty_i[k*TW +: TW] != '0);

  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  assert_irq_at_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $fell(run_o));
  assert_run_ends_by_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_o |=> (run_o || irq_o));
  assert_idle_timer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_o |-> (tmr_w == '0));
  assert_no_pwm_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_o & ~{NCH{run_o}}) == '0);
  assert_mode_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_o && !(arm_i && mode_i == 2'b10)) |=> !run_o);
  assert_start_outputs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_o && arm_i && mode_i == 2'b10) |=> (run_o && pwm_o == $past(nz)));
endmodule

bind oneshot_pwm oneshot_pwm_checker #(.NCH(NCH), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .arm_i(arm_i),
  .duty_i(duty_i), .pwm_o(pwm_o), .run_o(run_o), .irq_o(irq_o),
  .tmr_w(tmr_w)
);

// File: tb/oneshot_pwm_tb.sv
`timescale 1ns/1ps
module oneshot_pwm_tb;
  localparam int NCH = 3;
  localparam int TW  = 15;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [1:0]        mode_i;
  logic              arm_i;
  logic [TW-1:0]     period_i;
  logic [NCH*TW-1:0] duty_i;
  logic [NCH-1:0]    pwm_o;
  logic              run_o;
  logic              irq_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  oneshot_pwm #(.NCH(NCH), .TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .arm_i(arm_i),
    .period_i(period_i), .duty_i(duty_i), .pwm_o(pwm_o),
    .run_o(run_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_high(input int d, input int per);
    if (d == 0)  return 0;
    if (d > per) return per + 1;
    return d;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; mode_i = 2'b10; arm_i = 1'b0; period_i = '0; duty_i = '0;
    repeat (3) @(negedge clk);
    check("R1 run in reset", run_o, 0);
    check("R1 pwm in reset", pwm_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 run after reset", run_o, 0);
    check("R1 irq after reset", irq_o, 0);
    check("R1 pwm after reset", pwm_o, 0);
  endtask

  task automatic t_pulse(input int per, input int d0, input int d1, input int d2,
                         input bit mid_arm);
    int cyc = 0;
    int hi [NCH];
    int irq_seen = 0;
    int d [NCH];
    d[0] = d0; d[1] = d1; d[2] = d2;
    for (int k = 0; k < NCH; k++) hi[k] = 0;
    mode_i = 2'b10; period_i = TW'(per);
    duty_i = {TW'(d2), TW'(d1), TW'(d0)};
    @(negedge clk) arm_i = 1'b1;
    @(negedge clk) arm_i = 1'b0;
    check("R3 run after arm", run_o, 1);
    for (int k = 0; k < NCH; k++)
      check("R3 channel active at start", pwm_o[k], (d[k] != 0) ? 1 : 0);
    while (run_o && cyc < 2000) begin
      cyc++;
      for (int k = 0; k < NCH; k++) if (pwm_o[k]) hi[k]++;
      if (irq_o) irq_seen++;
      arm_i = (mid_arm && cyc == 2) ? 1'b1 : 1'b0;
      @(negedge clk);
    end
    arm_i = 1'b0;
    check(mid_arm ? "R9 run length with mid arm" : "R7 run length", cyc, per + 1);
    check("R8 no irq during run", irq_seen, 0);
    check("R8 irq at end", irq_o, 1);
    check("R6 pwm low at end", pwm_o, 0);
    for (int k = 0; k < NCH; k++)
      check(d[k] == 0 ? "R5 zero duty high count" :
            (d[k] > per ? "R6 long duty high count" : "R4 duty high count"),
            hi[k], exp_high(d[k], per));
    @(negedge clk);
    check("R8 irq single cycle", irq_o, 0);
    repeat (3) @(negedge clk);
    check("R10 stays idle run", run_o, 0);
    check("R10 stays idle pwm", pwm_o, 0);
    check("R10 no extra irq", irq_o, 0);
  endtask

  task automatic t_bad_modes();
    logic [1:0] mlist [3] = '{2'b00, 2'b01, 2'b11};
    period_i = TW'(5); duty_i = {TW'(2), TW'(2), TW'(2)};
    foreach (mlist[i]) begin
      mode_i = mlist[i];
      @(negedge clk) arm_i = 1'b1;
      @(negedge clk) arm_i = 1'b0;
      check("R2 other mode run", run_o, 0);
      check("R2 other mode pwm", pwm_o, 0);
      repeat (2) @(negedge clk);
      check("R2 other mode irq", irq_o, 0);
    end
    mode_i = 2'b10;
  endtask

  initial begin
    t_reset();
    t_pulse(9, 3, 5, 0, 1'b0);
    t_pulse(4, 4, 5, 20, 1'b0);
    t_pulse(0, 1, 0, 7, 1'b0);
    t_pulse(1, 1, 2, 0, 1'b0);
    t_pulse(12, 6, 12, 1, 1'b1);
    t_bad_modes();
    t_pulse(3, 2, 3, 4, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule